// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master. A programmable prescaler divides the system clock down to a module clock, and two separately programmed counts set how long SCL stays low and how long it is released high. On top of each programmed count, every phase is lengthened by a fixed extra delay `d` of module clocks. `d` depends on the prescaler setting: 7 when the prescaler value is 0, 6 when it is 1, and 5 when it is 2 or more. Software normally picks the prescaler so that the module clock falls between 7 and 12 MHz.

While `enable` is low, the generator is idle. Its counters are cleared and SCL is released. When `enable` goes high, the generator starts with a low phase and then alternates between low and high. The three settings are captured only at the start of each low phase, so a change applied part-way through a period never produces a truncated phase. During the high phase the generator watches the line. If another device holds SCL low, the high-phase count pauses until the line reads high again (clock stretching).

The block has no data stream. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure. `scl_in` must already be synchronous to `clk`, or `SYNC_STAGES` must be set above zero to add synchronizer flops.

Top module: `scl_clock_gen`

## Requirements
- R1: The phase counters advance once every (psc + 1) system clocks. The prescaler value multiplies both phase lengths by (psc + 1).
- R2: With `enable` held high, each low phase lasts exactly (clkl + d) × (psc + 1) system clocks.
- R3: When no device stretches the clock, each high phase lasts exactly (clkh + d) × (psc + 1) system clocks.
- R4: The extra delay d depends on the captured prescaler value: 7 when psc = 0, 6 when psc = 1, and 5 when psc ≥ 2.
- R5: Enabling and disabling behave as follows:
  - When `enable` is low at a clock edge, `scl_low_o` is 0 (line released) from the next cycle, and the counters restart.
  - When `enable` is high while idle, a low phase begins on the next cycle.
- R6: psc, clkl and clkh are captured only when a low phase begins. A change made during a phase takes effect from the next low phase.
- R7: During a high phase, a module-clock tick is counted only when `scl_in` reads 1. While the line is held low, SCL is not driven low again.
- R8: During a low phase, the level of `scl_in` has no effect on the phase length.
- R9: `edge_tick_o` is 1 for exactly one cycle, namely the first cycle after each change of `scl_low_o`, and is 0 otherwise.
- R10: During reset, `scl_low_o` and `edge_tick_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | 1 = generator running, 0 = held idle with SCL released |
| scl_in | input | 1 | Sensed SCL line level (1 = high) |
| psc | input | PSC_W | Prescaler setting; module clock = clk / (psc + 1) |
| clkl | input | DIV_W | Low-phase count before the extra delay d |
| clkh | input | DIV_W | High-phase count before the extra delay d |
| scl_low_o | output | 1 | 1 = pull SCL low, 0 = release it |
| edge_tick_o | output | 1 | One-cycle pulse after every SCL transition |

## Verification
The hardest case to reach is a stretched high phase. The line must be held low by something other than the generator, and the hold must end at a known module-clock count. The bench models the bus as open drain: the line is low if either the generator or a modelled slave pulls it low. The slave asserts its hold during a low phase, where R8 requires it to be ignored. It then releases the hold a fixed number of samples into the high phase, so the exact number of paused counts is known in advance. A second hard case is changing the settings mid-period. The bench rewrites them on the first high sample and checks that the current high phase keeps its old length while the following low phase uses the new one.

// File: rtl/scl_clock_gen_pkg.sv
package scl_clock_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Extra module clocks appended to each phase, selected by prescaler value.
  function automatic logic [2:0] ext_delay(input logic psc_is_zero, input logic psc_is_one);
    if (psc_is_zero)     return 3'd7;
    else if (psc_is_one) return 3'd6;
    else                 return 3'd5;
  endfunction

endpackage

// File: rtl/sclgen_cfg_latch.sv
module sclgen_cfg_latch #(
  parameter int PSC_W = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PSC_W-1:0] psc,
  input  logic [DIV_W-1:0] clkl,
  input  logic [DIV_W-1:0] clkh,
  output logic [PSC_W-1:0] psc_l,
  output logic [DIV_W-1:0] clkl_l,
  output logic [DIV_W-1:0] clkh_l
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_l  <= '0;
      clkl_l <= '0;
      clkh_l <= '0;
    end else if (load) begin
      psc_l  <= psc;
      clkl_l <= clkl;
      clkh_l <= clkh;
    end
  end

endmodule

// File: rtl/sclgen_prescaler.sv
module sclgen_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc_l,
  output logic             mod_tick
);

  logic [PSC_W-1:0] pcnt_q;

  assign mod_tick = run && (pcnt_q == psc_l);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt_q <= '0;
    else if (!run)     pcnt_q <= '0;
    else if (mod_tick) pcnt_q <= '0;
    else               pcnt_q <= pcnt_q + PSC_W'(1);
  end

endmodule

// File: rtl/sclgen_phase_ctrl.sv
module sclgen_phase_ctrl
  import scl_clock_gen_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             line_high,
  input  logic             mod_tick,
  input  logic [PSC_W-1:0] psc_l,
  input  logic [DIV_W-1:0] clkl_l,
  input  logic [DIV_W-1:0] clkh_l,
  output phase_e           phase_q,
  output logic             enter_low,
  output logic             edge_tick_q
);

  localparam int CNT_W = DIV_W + 1;

  phase_e           phase_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] low_term;
  logic [CNT_W-1:0] high_term;
  logic [2:0]       dly;
  logic             advance;

  assign dly       = ext_delay(psc_l == '0, psc_l == PSC_W'(1));
  assign low_term  = CNT_W'(clkl_l) + CNT_W'(dly) - CNT_W'(1);
  assign high_term = CNT_W'(clkh_l) + CNT_W'(dly) - CNT_W'(1);
  assign advance   = mod_tick && ((phase_q == PH_LOW) || ((phase_q == PH_HIGH) && line_high));

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (enable) phase_d = PH_LOW;
      PH_LOW: begin
        if (!enable)                          phase_d = PH_IDLE;
        else if (advance && cnt_q == low_term) phase_d = PH_HIGH;
      end
      PH_HIGH: begin
        if (!enable)                            phase_d = PH_IDLE;
        else if (advance && cnt_q == high_term) phase_d = PH_LOW;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign enter_low = (phase_d == PH_LOW) && (phase_q != PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      edge_tick_q <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      edge_tick_q <= (phase_d == PH_LOW) != (phase_q == PH_LOW);
      if (phase_d != phase_q) cnt_q <= '0;
      else if (advance)       cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_clock_gen_pkg::*;
#(
  parameter int PSC_W       = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             scl_in,
  input  logic [PSC_W-1:0] psc,
  input  logic [DIV_W-1:0] clkl,
  input  logic [DIV_W-1:0] clkh,
  output logic             scl_low_o,
  output logic             edge_tick_o
);

  localparam int CFG_W = PSC_W + 2 * DIV_W;

  logic             line_high;
  logic             mod_tick;
  logic             enter_low;
  logic             high_phase;
  logic [PSC_W-1:0] psc_l;
  logic [DIV_W-1:0] clkl_l;
  logic [DIV_W-1:0] clkh_l;
  logic [CFG_W-1:0] cfg_word;
  phase_e           phase_q;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign line_high = scl_in;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], scl_in};
      end
      assign line_high = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  sclgen_cfg_latch #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(enter_low),
    .psc(psc), .clkl(clkl), .clkh(clkh),
    .psc_l(psc_l), .clkl_l(clkl_l), .clkh_l(clkh_l)
  );

  sclgen_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(phase_q != PH_IDLE),
    .psc_l(psc_l), .mod_tick(mod_tick)
  );

  sclgen_phase_ctrl #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .enable(enable), .line_high(line_high),
    .mod_tick(mod_tick), .psc_l(psc_l), .clkl_l(clkl_l), .clkh_l(clkh_l),
    .phase_q(phase_q), .enter_low(enter_low), .edge_tick_q(edge_tick_o)
  );

  assign scl_low_o  = (phase_q == PH_LOW);
  assign high_phase = (phase_q == PH_HIGH);
  assign cfg_word   = {psc_l, clkl_l, clkh_l};

endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk #(
  parameter int CFG_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             line_high,
  input logic             high_phase,
  input logic             scl_low_o,
  input logic             edge_tick_o,
  input logic [CFG_W-1:0] cfg_word
);

  // R5: disabled generator releases the line on the next cycle
  p_release_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_low_o);

  // R9: every SCL change is marked by a tick
  p_edge_has_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_low_o != $past(scl_low_o)) |-> edge_tick_o);

  // R9: no tick without an SCL change
  p_tick_marks_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick_o |-> (scl_low_o != $past(scl_low_o)));

  // R7: a held-low line in the high phase blocks the next low phase
  p_hold_while_stretched_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && high_phase && !line_high) |=> !scl_low_o);

  // R6: captured settings move only at the start of a low phase
  p_cfg_only_at_low_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word != $past(cfg_word)) |-> $rose(scl_low_o));

endmodule

bind scl_clock_gen scl_clock_gen_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .line_high(line_high),
  .high_phase(high_phase), .scl_low_o(scl_low_o), .edge_tick_o(edge_tick_o),
  .cfg_word(cfg_word)
);

// File: tb/scl_clock_gen_tb.sv
module scl_clock_gen_tb;

  localparam int PSC_W = 8;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             hold = 1'b0;
  logic [PSC_W-1:0] psc = '0;
  logic [DIV_W-1:0] clkl = '0;
  logic [DIV_W-1:0] clkh = '0;
  logic             scl_low_o;
  logic             edge_tick_o;
  logic             scl_in;

  int n_checks = 0;
  int n_fail   = 0;

  // Open-drain bus: low if the generator or the modelled slave pulls it.
  assign scl_in = ~(scl_low_o | hold);

  always #4 clk = ~clk;

  scl_clock_gen #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in),
    .psc(psc), .clkl(clkl), .clkh(clkh),
    .scl_low_o(scl_low_o), .edge_tick_o(edge_tick_o)
  );

  // {psc, clkl, clkh, expected low clocks, expected high clocks}
  localparam int NV = 4;
  localparam int VEC [NV][5] = '{
    '{0, 3, 2, 10,  9},
    '{1, 4, 6, 20, 24},
    '{2, 0, 1, 15, 18},
    '{3, 2, 2, 28, 28}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_all();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Called at the first negedge sample of a phase; counts its samples.
  task automatic measure(input logic level, input int rel_at, output int n);
    n = 1;
    for (int guard = 0; guard < 5000; guard++) begin
      if (rel_at > 0 && n == rel_at) hold = 1'b0;
      @(negedge clk);
      if (scl_low_o == level) n++;
      else break;
    end
  endtask

  task automatic start_gen(input int p, input int l, input int h);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    psc = PSC_W'(p); clkl = DIV_W'(l); clkh = DIV_W'(h);
    enable = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_all();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(scl_low_o == 1'b0, "R10 scl during reset", scl_low_o, 0);
    check(edge_tick_o == 1'b0, "R10 tick during reset", edge_tick_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R9
    for (int i = 0; i < NV; i++) begin
      start_gen(VEC[i][0], VEC[i][1], VEC[i][2]);
      check(scl_low_o == 1'b1, "R5 low phase starts after enable", scl_low_o, 1);
      check(edge_tick_o == 1'b1, "R9 tick on falling edge", edge_tick_o, 1);
      measure(1'b1, 0, n);
      check(n == VEC[i][3], "R2 R4 R1 low length", n, VEC[i][3]);
      check(edge_tick_o == 1'b1, "R9 tick on rising edge", edge_tick_o, 1);
      measure(1'b0, 0, n);
      check(n == VEC[i][4], "R3 R4 R1 high length", n, VEC[i][4]);
      measure(1'b1, 0, n);
      check(n == VEC[i][3], "R2 repeated low length", n, VEC[i][3]);
    end

    // R5 and R9: disabling mid-low releases the line with one tick
    start_gen(0, 3, 2);
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(scl_low_o == 1'b0, "R5 released after disable", scl_low_o, 0);
    check(edge_tick_o == 1'b1, "R9 tick on release", edge_tick_o, 1);
    n = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (scl_low_o || edge_tick_o) n++;
    end
    check(n == 0, "R5 R9 idle stays released, no ticks", n, 0);

    // R6: settings changed in the high phase apply to the next low phase
    start_gen(0, 3, 2);
    measure(1'b1, 0, n);
    clkl = DIV_W'(1); clkh = DIV_W'(10);
    measure(1'b0, 0, n);
    check(n == 9, "R6 current high keeps old setting", n, 9);
    measure(1'b1, 0, n);
    check(n == 8, "R6 next low uses new setting", n, 8);
    measure(1'b0, 0, n);
    check(n == 17, "R6 next high uses new setting", n, 17);

    // R8 then R7: slave holds the line low from the low phase into the high phase
    start_gen(0, 3, 2);
    hold = 1'b1;
    measure(1'b1, 0, n);
    check(n == 10, "R8 hold in low phase ignored", n, 10);
    measure(1'b0, 6, n);
    check(n == 14, "R7 stretched high length", n, 14);
    measure(1'b1, 0, n);
    check(n == 10, "R7 low after stretch", n, 10);

    enable = 1'b0;
    repeat (3) @(negedge clk);
    finish_all();
  end

endmodule